// File: doc/BRIEF.md
# Tape Transport and Step Sequencer

This block holds a finite row of symbol cells with a single head, and it also runs the machine-level control around a programmed controller. When the reset button is pressed, or after power-on reset, it homes the head. It does this by issuing step-left commands to itself until the left-of-leftmost error appears. The head is then on cell 0. Next it holds the controller in reset until the button is released.

After release, the block sends one step pulse per clock while the halt line is low. In each cycle with a step pulse it executes the command from the controller: no-op, step left, step right, or write a symbol. The symbol under the head is always visible on the read output. Once halt is seen while running, stepping stops and stays stopped until the next button press.

While the button is held, the tape contents can be loaded through a preload port. At all other times that port is ignored.

Top module: `tape_unit`

## Requirements
- R1: After reset or a button press, the head steps left one cell per cycle until the left error flag is seen. The controller-reset output then rises with the head on cell 0.
- R2: ctrl_rst_o stays high while reset_btn is held after homing and falls on the edge after release. step_o is low whenever ctrl_rst_o is high.
- R3: In the running state, step_o is high in every cycle in which halt_i and reset_btn are both low.
- R4: halt_i high in a running cycle drops step_o in that cycle. step_o then stays low in every later cycle, whatever halt_i does, until reset_btn is pressed.
- R5: Command code 2'b01 (step left) in a step cycle moves the head down by one. At cell 0 the head stays put and left_err_o is high for exactly the next cycle.
- R6: Command code 2'b10 (step right) in a step cycle moves the head up by one. At cell CELLS-1 the head stays put and right_err_o is high for exactly the next cycle.
- R7: Command code 2'b11 (write) in a step cycle stores wr_sym_i into the cell under the head. The stored value appears on rd_sym_o from the next cycle, and the head does not move. Code 2'b00 is a no-op.
- R8: rd_sym_o always shows the content of the cell at head_pos_o.
- R9: A preload write (pre_we_i) takes effect only while reset_btn is high. Otherwise the tape is unchanged.
- R10: Controller commands have no effect in any cycle without a step pulse. This covers the halted state and the controller-reset state.
- R11: While rst_n is low, step_o, ctrl_rst_o, left_err_o and right_err_o are low, the head is on cell 0 and every cell holds 0.
- R12: reset_btn high while running or halted drops step_o in the same cycle and restarts homing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reset_btn | input | 1 | Machine reset button, active high |
| halt_i | input | 1 | Halt request from the controller's halt comparator |
| cmd_i | input | 2 | Command: 00 no-op, 01 left, 10 right, 11 write |
| wr_sym_i | input | SYM_W | Symbol for a write command |
| pre_we_i | input | 1 | Preload write strobe, honoured only with reset_btn high |
| pre_addr_i | input | POS_W | Preload cell index |
| pre_sym_i | input | SYM_W | Preload symbol |
| rd_sym_o | output | SYM_W | Symbol under the head |
| head_pos_o | output | POS_W | Current head cell |
| left_err_o | output | 1 | Step left attempted at cell 0 (one cycle) |
| right_err_o | output | 1 | Step right attempted at the last cell (one cycle) |
| step_o | output | 1 | Step pulse to the controller |
| ctrl_rst_o | output | 1 | Controller reset, held until button release |

## Verification
The properties assume that halt_i and cmd_i are only meaningful in step cycles, and that the preload port changes nothing when the button is up. The properties also take reset_btn as a clean level, sampled on the clock. The stimulus keeps reset_btn low through the random run phase and raises it only in directed homing sequences. It drives random commands, symbols and stray preload strobes, so that every step also tests that preload is ignored. Halt is raised only in directed cases, after the head has been placed mid-tape.

// File: rtl/tape_pkg.sv
package tape_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_LEFT  = 2'b01,
    CMD_RIGHT = 2'b10,
    CMD_WRITE = 2'b11
  } tape_cmd_e;

  typedef enum logic [1:0] {
    SEQ_HOME = 2'd0,
    SEQ_CRST = 2'd1,
    SEQ_RUN  = 2'd2,
    SEQ_HALT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tape_store.sv
module tape_store #(
  parameter int CELLS = 16,
  parameter int SYM_W = 4,
  localparam int POS_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [POS_W-1:0] wr_pos,
  input  logic [SYM_W-1:0] wr_sym,
  input  logic             pre_en,
  input  logic [POS_W-1:0] pre_pos,
  input  logic [SYM_W-1:0] pre_sym,
  input  logic [POS_W-1:0] rd_pos,
  output logic [SYM_W-1:0] rd_sym
);
  logic [SYM_W-1:0] cell_q [CELLS];

  for (genvar gi = 0; gi < CELLS; gi++) begin : g_cell
    logic             pre_hit;
    logic             wr_hit;
    logic             cell_en;
    logic [SYM_W-1:0] cell_d;

    always_comb begin
      pre_hit = pre_en && (pre_pos == POS_W'(gi));
      wr_hit  = wr_en && (wr_pos == POS_W'(gi));
      cell_en = pre_hit || wr_hit;
      cell_d  = pre_hit ? pre_sym : wr_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[gi] <= '0;
      end else if (cell_en) begin
        cell_q[gi] <= cell_d;
      end
    end
  end

  assign rd_sym = cell_q[rd_pos];
endmodule

// File: rtl/head_ctrl.sv
module head_ctrl
  import tape_pkg::*;
#(
  parameter int CELLS = 16,
  localparam int POS_W = $clog2(CELLS),
  localparam logic [POS_W-1:0] LAST = POS_W'(CELLS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tape_cmd_e        cmd,
  output logic [POS_W-1:0] pos_o,
  output logic             left_err_o,
  output logic             right_err_o,
  output logic             wr_en_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;
  logic             lerr_q, lerr_d;
  logic             rerr_q, rerr_d;

  always_comb begin
    pos_d  = pos_q;
    lerr_d = 1'b0;
    rerr_d = 1'b0;
    unique case (cmd)
      CMD_LEFT: begin
        if (pos_q == '0) lerr_d = 1'b1;
        else             pos_d  = pos_q - 1'b1;
      end
      CMD_RIGHT: begin
        if (pos_q == LAST) rerr_d = 1'b1;
        else               pos_d  = pos_q + 1'b1;
      end
      default: ;
    endcase
    pos_en = (pos_d != pos_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lerr_q <= 1'b0;
      rerr_q <= 1'b0;
    end else begin
      lerr_q <= lerr_d;
      rerr_q <= rerr_d;
    end
  end

  assign pos_o       = pos_q;
  assign left_err_o  = lerr_q;
  assign right_err_o = rerr_q;
  assign wr_en_o     = (cmd == CMD_WRITE);
endmodule

// File: rtl/step_seq.sv
module step_seq
  import tape_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reset_btn,
  input  logic      halt_i,
  input  logic      left_err_i,
  input  tape_cmd_e ext_cmd,
  output tape_cmd_e eff_cmd_o,
  output logic      step_o,
  output logic      ctrl_rst_o
);
  seq_state_e state_q, state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_HOME: if (left_err_i) state_d = SEQ_CRST;
      SEQ_CRST: if (!reset_btn) state_d = SEQ_RUN;
      SEQ_RUN: begin
        if (reset_btn)   state_d = SEQ_HOME;
        else if (halt_i) state_d = SEQ_HALT;
      end
      SEQ_HALT: if (reset_btn) state_d = SEQ_HOME;
      default: state_d = SEQ_HOME;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_HOME;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    step_o     = (state_q == SEQ_RUN) && !halt_i && !reset_btn;
    ctrl_rst_o = (state_q == SEQ_CRST);
    if ((state_q == SEQ_HOME) && !left_err_i) eff_cmd_o = CMD_LEFT;
    else if (step_o)                           eff_cmd_o = ext_cmd;
    else                                       eff_cmd_o = CMD_NOP;
  end
endmodule

// File: rtl/tape_unit.sv
module tape_unit
  import tape_pkg::*;
#(
  parameter int CELLS = 16,
  parameter int SYM_W = 4,
  localparam int POS_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_btn,
  input  logic             halt_i,
  input  logic [1:0]       cmd_i,
  input  logic [SYM_W-1:0] wr_sym_i,
  input  logic             pre_we_i,
  input  logic [POS_W-1:0] pre_addr_i,
  input  logic [SYM_W-1:0] pre_sym_i,
  output logic [SYM_W-1:0] rd_sym_o,
  output logic [POS_W-1:0] head_pos_o,
  output logic             left_err_o,
  output logic             right_err_o,
  output logic             step_o,
  output logic             ctrl_rst_o
);
  tape_cmd_e        eff_cmd;
  logic             wr_en;
  logic             pre_en;
  logic [POS_W-1:0] head_pos;
  logic             lerr;

  assign pre_en = pre_we_i && reset_btn;

  step_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_btn  (reset_btn),
    .halt_i     (halt_i),
    .left_err_i (lerr),
    .ext_cmd    (tape_cmd_e'(cmd_i)),
    .eff_cmd_o  (eff_cmd),
    .step_o     (step_o),
    .ctrl_rst_o (ctrl_rst_o)
  );

  head_ctrl #(.CELLS(CELLS)) u_head (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (eff_cmd),
    .pos_o       (head_pos),
    .left_err_o  (lerr),
    .right_err_o (right_err_o),
    .wr_en_o     (wr_en)
  );

  tape_store #(.CELLS(CELLS), .SYM_W(SYM_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_pos  (head_pos),
    .wr_sym  (wr_sym_i),
    .pre_en  (pre_en),
    .pre_pos (pre_addr_i),
    .pre_sym (pre_sym_i),
    .rd_pos  (head_pos),
    .rd_sym  (rd_sym_o)
  );

  assign head_pos_o = head_pos;
  assign left_err_o = lerr;
endmodule

// File: rtl/tape_unit_chk.sv
module tape_unit_chk #(
  parameter int CELLS = 16,
  parameter int SYM_W = 4,
  localparam int POS_W = $clog2(CELLS),
  localparam logic [POS_W-1:0] LAST = POS_W'(CELLS - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reset_btn,
  input logic             halt_i,
  input logic [1:0]       cmd_i,
  input logic [SYM_W-1:0] wr_sym_i,
  input logic [SYM_W-1:0] rd_sym_o,
  input logic [POS_W-1:0] head_pos_o,
  input logic             left_err_o,
  input logic             right_err_o,
  input logic             step_o,
  input logic             ctrl_rst_o
);
  logic step_d_q;
  logic halted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_d_q <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      step_d_q <= step_o;
      if (reset_btn)                 halted_q <= 1'b0;
      else if (halt_i && step_d_q)   halted_q <= 1'b1;
    end
  end

  AST_HOMED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_o) |-> head_pos_o == '0); // R1
  AST_NO_STEP_IN_CRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_o |-> !step_o); // R2
  AST_STEP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> !halt_i); // R3
  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |-> !step_o); // R4
  AST_LEFT_ERR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    left_err_o |-> (head_pos_o == '0) && $stable(head_pos_o)); // R5
  AST_RIGHT_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    right_err_o |-> (head_pos_o == LAST) && $stable(head_pos_o)); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_err_o && right_err_o)); // R5
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && cmd_i == 2'b11) |=> rd_sym_o == $past(wr_sym_i)); // R7
  AST_HEAD_STILL_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_o && !ctrl_rst_o && !reset_btn && halted_q) |=> $stable(head_pos_o)); // R10
  AST_BTN_BLOCKS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reset_btn |-> !step_o); // R12
endmodule

bind tape_unit tape_unit_chk #(.CELLS(CELLS), .SYM_W(SYM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reset_btn   (reset_btn),
  .halt_i      (halt_i),
  .cmd_i       (cmd_i),
  .wr_sym_i    (wr_sym_i),
  .rd_sym_o    (rd_sym_o),
  .head_pos_o  (head_pos_o),
  .left_err_o  (left_err_o),
  .right_err_o (right_err_o),
  .step_o      (step_o),
  .ctrl_rst_o  (ctrl_rst_o)
);

// File: tb/tb_tape_unit.sv
module tb_tape_unit;
  localparam int CELLS = 16;
  localparam int SYM_W = 4;
  localparam int POS_W = $clog2(CELLS);

  logic             clk;
  logic             rst_n;
  logic             reset_btn;
  logic             halt_i;
  logic [1:0]       cmd_i;
  logic [SYM_W-1:0] wr_sym_i;
  logic             pre_we_i;
  logic [POS_W-1:0] pre_addr_i;
  logic [SYM_W-1:0] pre_sym_i;
  logic [SYM_W-1:0] rd_sym_o;
  logic [POS_W-1:0] head_pos_o;
  logic             left_err_o;
  logic             right_err_o;
  logic             step_o;
  logic             ctrl_rst_o;

  tape_unit #(.CELLS(CELLS), .SYM_W(SYM_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  logic [SYM_W-1:0] m_cell [CELLS];
  int   m_head;
  bit   m_running;
  bit   done = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic bit exp_step(input bit h);
    return m_running && !h;
  endfunction

  // One modelled cycle with reset_btn low.
  task automatic run_cycle(input logic [1:0] c, input logic [SYM_W-1:0] w, input bit h,
                           input bit pw, input logic [POS_W-1:0] pa, input logic [SYM_W-1:0] ps);
    bit st, el, er;
    string rq;
    @(negedge clk);
    reset_btn = 1'b0; halt_i = h; cmd_i = c; wr_sym_i = w;
    pre_we_i = pw; pre_addr_i = pa; pre_sym_i = ps;
    #1;
    st = exp_step(h);
    chk(m_running ? "R3" : "R4", "step_o", int'(step_o), int'(st));
    el = 0; er = 0;
    if (st) begin
      case (c)
        2'b01: if (m_head == 0) el = 1; else m_head--;
        2'b10: if (m_head == CELLS - 1) er = 1; else m_head++;
        2'b11: m_cell[m_head] = w;
        default: ;
      endcase
    end
    if (m_running && h) m_running = 0;
    @(posedge clk); #1;
    rq = (!st && c != 2'b00) ? "R10" : (c == 2'b10 ? "R6" : "R5");
    chk(rq, "head_pos_o", int'(head_pos_o), m_head);
    chk("R5", "left_err_o", int'(left_err_o), int'(el));
    chk("R6", "right_err_o", int'(right_err_o), int'(er));
    rq = pw ? "R9" : (c == 2'b11 ? "R7" : "R8");
    chk(rq, "rd_sym_o", int'(rd_sym_o), int'(m_cell[m_head]));
  endtask

  // Button held: drive preload, return once ctrl_rst_o is seen.
  task automatic home_and_wait(input string req, input bit do_load);
    int n = 0;
    bit bad_step = 0;
    while (!ctrl_rst_o && n < 4 * CELLS) begin
      @(negedge clk);
      reset_btn = 1'b1; halt_i = 1'b0; cmd_i = 2'b10; pre_we_i = 1'b0;
      #1;
      if (step_o) bad_step = 1;
      n++;
    end
    chk(req, "homing done within bound", int'(ctrl_rst_o), 1);
    chk(req, "no step while homing", int'(bad_step), 0);
    chk(req, "head homed to cell 0", int'(head_pos_o), 0);
    m_head = 0;
    if (do_load) begin
      for (int i = 0; i < CELLS; i++) begin
        @(negedge clk);
        pre_we_i = 1'b1; pre_addr_i = POS_W'(i);
        pre_sym_i = SYM_W'($urandom);
        m_cell[i] = pre_sym_i;
        #1;
        chk("R2", "ctrl_rst_o held", int'(ctrl_rst_o), 1);
        chk("R2", "step_o low in controller reset", int'(step_o), 0);
      end
      @(negedge clk);
      pre_we_i = 1'b0;
    end
    @(negedge clk);
    reset_btn = 1'b0;
    @(posedge clk); #1;
    chk("R2", "ctrl_rst_o falls after release", int'(ctrl_rst_o), 0);
    chk("R9", "preloaded cell 0 visible", int'(rd_sym_o), int'(m_cell[0]));
    m_running = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; reset_btn = 1'b1; halt_i = 1'b0; cmd_i = 2'b00;
    wr_sym_i = '0; pre_we_i = 1'b0; pre_addr_i = '0; pre_sym_i = '0;
    m_running = 0; m_head = 0;
    for (int i = 0; i < CELLS; i++) m_cell[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "step_o in reset", int'(step_o), 0);
    chk("R11", "ctrl_rst_o in reset", int'(ctrl_rst_o), 0);
    chk("R11", "left_err_o in reset", int'(left_err_o), 0);
    chk("R11", "right_err_o in reset", int'(right_err_o), 0);
    chk("R11", "head in reset", int'(head_pos_o), 0);
    chk("R11", "cell 0 in reset", int'(rd_sym_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    home_and_wait("R1", 1'b1);

    // Directed edges: left at 0, then run to the right end.
    run_cycle(2'b01, '0, 0, 0, '0, '0);
    for (int i = 0; i < CELLS; i++) run_cycle(2'b10, '0, 0, 0, '0, '0);
    run_cycle(2'b11, 4'hA, 0, 0, '0, '0);
    run_cycle(2'b00, '0, 0, 0, '0, '0);

    // Random run with stray preload strobes.
    for (int k = 0; k < 400; k++) begin
      run_cycle(2'($urandom), SYM_W'($urandom), 0, bit'($urandom_range(0, 3) == 0),
                POS_W'($urandom), SYM_W'($urandom));
    end

    // Place head mid-tape, then halt.
    while (m_head != 5) run_cycle(m_head > 5 ? 2'b01 : 2'b10, '0, 0, 0, '0, '0);
    run_cycle(2'b10, '0, 1, 0, '0, '0);
    for (int k = 0; k < 8; k++) run_cycle(2'($urandom), SYM_W'($urandom), 0, 0, '0, '0);
    run_cycle(2'b01, '0, 1, 0, '0, '0);

    // Button while halted: homing restarts (R12).
    @(negedge clk);
    reset_btn = 1'b1;
    #1;
    chk("R12", "step_o low with button", int'(step_o), 0);
    m_running = 0;
    home_and_wait("R12", 1'b0);

    // Button during running drops step at once.
    run_cycle(2'b10, '0, 0, 0, '0, '0);
    run_cycle(2'b10, '0, 0, 0, '0, '0);
    @(negedge clk);
    reset_btn = 1'b1; cmd_i = 2'b10;
    #1;
    chk("R12", "step_o low on press in run", int'(step_o), 0);
    m_running = 0;
    home_and_wait("R1", 1'b1);
    for (int k = 0; k < 50; k++) run_cycle(2'($urandom), SYM_W'($urandom), 0, 0, '0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule